// File: doc/BRIEF.md
# UDP/IPv4 Transmit Frame Builder

This block turns a handful of per-packet values into a complete Ethernet II / IPv4 / UDP frame and hands it to a MAC transmit port as a stream of 32-bit words, most significant byte first. A single start pulse captures both MAC addresses, both IP addresses, both UDP ports, the IP identification, the flags/fragment field and the payload byte count. Because the values are captured on every start, each packet can carry different header contents.

Before the first word leaves, the block runs a short checksum pass. It clears an accumulator for one cycle and then adds five 32-bit header words, both halves of each, over five cycles. The resulting ones'-complement sum is folded twice and inverted to give the IPv4 header checksum. The ten header words then go out in order with the checksum in its slot. After them the payload is pulled from a FIFO-style source. The 14-byte Ethernet header leaves the IP and UDP fields misaligned with the 32-bit words, so the payload is shifted by 16 bits across output words. The first two payload bytes share a word with the zero UDP checksum. The final word is flagged and carries a byte-enable.

The control is a five-state machine. IDLE waits for start and goes to CLR. CLR clears the accumulator and goes to SUM. SUM spends five cycles accumulating and goes to HDR. HDR emits header words 0 to 9, advancing on ready, and goes to PAY after word 9 is accepted. PAY emits the payload words and returns to IDLE when the last word is accepted.

Top module: `udpf_tx`

## Requirements
- R1: During and right after reset, busy, tx_valid and pay_ready are all low.
- R2: A start pulse while idle captures every field input and pay_len, and busy goes high on the next cycle. Busy stays high until the final word is accepted and then drops. A start while busy is ignored: the running frame is unchanged and no second frame follows it.
- R3: With tx_ready held high, tx_valid stays low for the six cycles after the start edge (one clear plus five accumulate cycles) and first goes high in the seventh.
- R4: Words 0 to 2 carry dst_mac[47:16], then {dst_mac[15:0], src_mac[47:32]}, then src_mac[31:0].
- R5: Word 3 is 0x08004500. Word 4 is {IP total length, ident}, where total length = 28 + pay_len. Word 5 is {frag, 0x40, 0x11}.
- R6: Word 6 is {checksum, src_ip[31:16]}. The checksum is the inverted ones'-complement sum of the ten IPv4 header halfwords, with the checksum field counted as zero and every carry folded back, including a carry produced by the first fold.
- R7: Word 7 is {src_ip[15:0], dst_ip[31:16]}. Word 8 is {dst_ip[15:0], src_port}. Word 9 is {dst_port, UDP length}, where UDP length = 8 + pay_len.
- R8: Word 10 is {0x0000, payload byte 0, payload byte 1}. Every later word holds the next four payload bytes in stream order, byte n of the payload being byte n%4 of source word n/4, with the first byte in bits 31:24.
- R9: A word advances only on a cycle with tx_valid and tx_ready both high. While a header word is stalled, tx_valid and tx_data hold.
- R10: pay_ready is high only during the payload phase, while tx_ready is high and a payload word remains. Exactly ceil(pay_len/4) source words are consumed per frame.
- R11: The frame is ceil((42+pay_len)/4) words long, and tx_last marks only the final one. tx_keep bit 3 enables bits 31:24. It is 0xF on every non-final word. On the final word it is 0xF, 0x8, 0xC or 0xE for (42+pay_len)%4 equal to 0, 1, 2 or 3, and the disabled bytes are zero.
- R12: With pay_len = 0, the frame is 11 words long, the last being 0x00000000 with tx_keep 0xC, and no source word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture fields and begin a frame (idle only) |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | UDP source port |
| dst_port | input | 16 | UDP destination port |
| ident | input | 16 | IPv4 identification |
| frag | input | 16 | IPv4 flags and fragment offset |
| pay_len | input | PLEN_W | Payload length in bytes (at most 65507) |
| busy | output | 1 | Frame in progress |
| pay_data | input | 32 | Payload source word, first byte in bits 31:24 |
| pay_valid | input | 1 | Payload source word available |
| pay_ready | output | 1 | Payload source word consumed this cycle |
| tx_data | output | 32 | Frame word to the MAC |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | MAC accepts the word |
| tx_last | output | 1 | Final word of the frame |
| tx_keep | output | 4 | Byte enables, bit 3 for bits 31:24 |

## Verification
The bench uses the default parameters: PLEN_W = 16 and TTL = 0x40. The 16-bit length lets it run a 31,444-byte payload with all-ones identification, fragment and address fields. That pushes the header sum to 0x6FFFB, where the first fold itself carries and only the second fold gives the right checksum, 0xFFFD. Shorter frames cover all four tail alignments, the empty payload, back-pressure on both sides and a start pulse made mid-frame.

// File: rtl/udpf_pkg.sv
package udpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_SUM,
        ST_HDR,
        ST_PAY
    } state_t;

    typedef struct packed {
        logic [47:0] dmac;
        logic [47:0] smac;
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [15:0] ident;
        logic [15:0] frag;
        logic [15:0] ip_len;
        logic [15:0] udp_len;
    } hdr_t;

    localparam int          HDR_WORDS  = 10;
    localparam int          SUM_WORDS  = 5;
    localparam int          IP_HDR_B   = 20;
    localparam int          UDP_HDR_B  = 8;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] VER_IHL    = 16'h4500;
    localparam logic [7:0]  PROTO_UDP  = 8'h11;

    function automatic logic [31:0] keep_mask(input logic [3:0] keep);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) begin
            m[8*b +: 8] = {8{keep[b]}};
        end
        return m;
    endfunction

    function automatic logic [3:0] tail_keep(input logic [1:0] rem);
        logic [3:0] k;
        unique case (rem)
            2'd0: k = 4'hF;
            2'd1: k = 4'h8;
            2'd2: k = 4'hC;
            2'd3: k = 4'hE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/udpf_csum.sv
module udpf_csum #(
    parameter int N_WORDS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add_en,
    input  logic [31:0] word,
    output logic [15:0] csum
);
    localparam int ACC_W = 16 + $clog2(2 * N_WORDS);

    logic [ACC_W-1:0] acc_q;
    logic [16:0]      fold1;
    logic [15:0]      fold2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= acc_q + ACC_W'(word[31:16]) + ACC_W'(word[15:0]);
        end
    end

    always_comb begin
        fold1 = {1'b0, acc_q[15:0]} + 17'(acc_q[ACC_W-1:16]);
        fold2 = fold1[15:0] + 16'(fold1[16]);
        csum  = ~fold2;
    end

endmodule

// File: rtl/udpf_hdr.sv
module udpf_hdr
    import udpf_pkg::*;
#(
    parameter logic [7:0] TTL = 8'h40
) (
    input  hdr_t        fld,
    input  logic [3:0]  hdr_idx,
    input  logic [2:0]  sum_idx,
    input  logic [15:0] csum,
    output logic [31:0] hdr_word,
    output logic [31:0] sum_word
);

    always_comb begin
        unique case (hdr_idx)
            4'd0:    hdr_word = fld.dmac[47:16];
            4'd1:    hdr_word = {fld.dmac[15:0], fld.smac[47:32]};
            4'd2:    hdr_word = fld.smac[31:0];
            4'd3:    hdr_word = {ETYPE_IPV4, VER_IHL};
            4'd4:    hdr_word = {fld.ip_len, fld.ident};
            4'd5:    hdr_word = {fld.frag, TTL, PROTO_UDP};
            4'd6:    hdr_word = {csum, fld.sip[31:16]};
            4'd7:    hdr_word = {fld.sip[15:0], fld.dip[31:16]};
            4'd8:    hdr_word = {fld.dip[15:0], fld.sport};
            4'd9:    hdr_word = {fld.dport, fld.udp_len};
            default: hdr_word = '0;
        endcase
    end

    always_comb begin
        unique case (sum_idx)
            3'd0:    sum_word = {VER_IHL, fld.ip_len};
            3'd1:    sum_word = {fld.ident, fld.frag};
            3'd2:    sum_word = {TTL, PROTO_UDP, 16'h0000};
            3'd3:    sum_word = fld.sip;
            3'd4:    sum_word = fld.dip;
            default: sum_word = '0;
        endcase
    end

endmodule

// File: rtl/udpf_align.sv
module udpf_align (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        first,
    input  logic        have_in,
    input  logic        take,
    input  logic [31:0] in_data,
    output logic [31:0] out_word
);
    logic [15:0] low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (take) begin
            low_q <= in_data[15:0];
        end
    end

    always_comb begin
        out_word[31:16] = first   ? 16'h0000        : low_q;
        out_word[15:0]  = have_in ? in_data[31:16] : 16'h0000;
    end

endmodule

// File: rtl/udpf_tx.sv
module udpf_tx
    import udpf_pkg::*;
#(
    parameter int         PLEN_W = 16,
    parameter logic [7:0] TTL    = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [47:0]       dst_mac,
    input  logic [47:0]       src_mac,
    input  logic [31:0]       src_ip,
    input  logic [31:0]       dst_ip,
    input  logic [15:0]       src_port,
    input  logic [15:0]       dst_port,
    input  logic [15:0]       ident,
    input  logic [15:0]       frag,
    input  logic [PLEN_W-1:0] pay_len,
    output logic              busy,
    input  logic [31:0]       pay_data,
    input  logic              pay_valid,
    output logic              pay_ready,
    output logic [31:0]       tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic [3:0]        tx_keep
);
    localparam int          CNT_W    = PLEN_W + 1;
    localparam logic [3:0]  HDR_LAST = 4'(HDR_WORDS - 1);
    localparam logic [2:0]  SUM_LAST = 3'(SUM_WORDS - 1);

    state_t            state_q, state_d;
    hdr_t              fld_q;
    logic [3:0]        idx_q;
    logic [CNT_W-1:0]  j_q;
    logic [CNT_W-1:0]  pwords_q;
    logic [CNT_W-1:0]  owords_q;
    logic [3:0]        lkeep_q;

    logic [CNT_W-1:0]  plen_ext;
    logic [1:0]        tail_rem;
    logic              hdr_phase;
    logic              pay_phase;
    logic              have_in;
    logic              final_word;
    logic              word_take;
    logic              csum_clr;
    logic              csum_add;
    logic [15:0]       csum;
    logic [31:0]       hdr_word;
    logic [31:0]       sum_word;
    logic [31:0]       pay_word;

    assign plen_ext = CNT_W'(pay_len);
    assign tail_rem = pay_len[1:0] + 2'd2;

    // State register, counters and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fld_q    <= '0;
            idx_q    <= '0;
            j_q      <= '0;
            pwords_q <= '0;
            owords_q <= '0;
            lkeep_q  <= 4'hF;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fld_q.dmac    <= dst_mac;
                        fld_q.smac    <= src_mac;
                        fld_q.sip     <= src_ip;
                        fld_q.dip     <= dst_ip;
                        fld_q.sport   <= src_port;
                        fld_q.dport   <= dst_port;
                        fld_q.ident   <= ident;
                        fld_q.frag    <= frag;
                        fld_q.ip_len  <= 16'(pay_len) + 16'(IP_HDR_B + UDP_HDR_B);
                        fld_q.udp_len <= 16'(pay_len) + 16'(UDP_HDR_B);
                        pwords_q      <= (plen_ext + CNT_W'(3)) >> 2;
                        owords_q      <= (plen_ext + CNT_W'(5)) >> 2;
                        lkeep_q       <= tail_keep(tail_rem);
                    end
                end
                ST_CLR: begin
                    idx_q <= '0;
                    j_q   <= '0;
                end
                ST_SUM: begin
                    idx_q <= (idx_q[2:0] == SUM_LAST) ? 4'd0 : idx_q + 4'd1;
                end
                ST_HDR: begin
                    if (tx_ready) begin
                        idx_q <= idx_q + 4'd1;
                    end
                end
                ST_PAY: begin
                    if (word_take) begin
                        j_q <= j_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CLR;
            ST_CLR:  state_d = ST_SUM;
            ST_SUM:  if (idx_q[2:0] == SUM_LAST) state_d = ST_HDR;
            ST_HDR:  if (tx_ready && idx_q == HDR_LAST) state_d = ST_PAY;
            ST_PAY:  if (word_take && final_word) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hdr_phase  = (state_q == ST_HDR);
        pay_phase  = (state_q == ST_PAY);
        busy       = (state_q != ST_IDLE);
        csum_clr   = (state_q == ST_CLR);
        csum_add   = (state_q == ST_SUM);
        have_in    = (j_q < pwords_q);
        final_word = (j_q == owords_q - CNT_W'(1));
        tx_valid   = 1'b0;
        tx_data    = '0;
        tx_last    = 1'b0;
        tx_keep    = 4'hF;
        pay_ready  = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_data  = hdr_word;
            end
            ST_PAY: begin
                tx_valid  = have_in ? pay_valid : 1'b1;
                tx_last   = final_word;
                tx_keep   = final_word ? lkeep_q : 4'hF;
                tx_data   = pay_word & keep_mask(tx_keep);
                pay_ready = have_in && tx_ready;
            end
            default: ;
        endcase
        word_take = pay_phase && tx_valid && tx_ready;
    end

    udpf_csum #(
        .N_WORDS (SUM_WORDS)
    ) u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (csum_clr),
        .add_en (csum_add),
        .word   (sum_word),
        .csum   (csum)
    );

    udpf_hdr #(
        .TTL (TTL)
    ) u_hdr (
        .fld      (fld_q),
        .hdr_idx  (idx_q),
        .sum_idx  (idx_q[2:0]),
        .csum     (csum),
        .hdr_word (hdr_word),
        .sum_word (sum_word)
    );

    udpf_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .first    (j_q == '0),
        .have_in  (have_in),
        .take     (pay_valid && pay_ready),
        .in_data  (pay_data),
        .out_word (pay_word)
    );

endmodule

// File: rtl/udpf_tx_chk.sv
module udpf_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        hdr_phase,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_last,
    input logic [3:0]  tx_keep,
    input logic [31:0] tx_data,
    input logic        pay_ready
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !pay_ready)); // R1

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_CSUM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_valid); // R3

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_phase && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9

    AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (tx_ready && busy && !hdr_phase)); // R10

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !busy); // R11

    AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |-> (tx_keep == 4'hF)); // R11

endmodule

bind udpf_tx udpf_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .hdr_phase (hdr_phase),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .tx_keep   (tx_keep),
    .tx_data   (tx_data),
    .pay_ready (pay_ready)
);

// File: tb/udpf_tx_bench.sv
module udpf_tx_bench;
    localparam int PLEN_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [47:0]       dst_mac, src_mac;
    logic [31:0]       src_ip, dst_ip;
    logic [15:0]       src_port, dst_port, ident, frag;
    logic [PLEN_W-1:0] pay_len;
    logic              busy;
    logic [31:0]       pay_data;
    logic              pay_valid;
    logic              pay_ready;
    logic [31:0]       tx_data;
    logic              tx_valid;
    logic              tx_ready;
    logic              tx_last;
    logic [3:0]        tx_keep;

    int          nchk  = 0;
    int          nfail = 0;
    int          seed  = 0;
    logic [7:0]  hb [0:41];
    logic [15:0] exp_csum;

    always #10 clk = ~clk;

    udpf_tx #(.PLEN_W(PLEN_W)) u_udpf_tx (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dst_mac(dst_mac), .src_mac(src_mac), .src_ip(src_ip), .dst_ip(dst_ip),
        .src_port(src_port), .dst_port(dst_port), .ident(ident), .frag(frag),
        .pay_len(pay_len), .busy(busy),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .tx_keep(tx_keep)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int i);
        return 8'((i * 37 + seed) ^ (i >> 7));
    endfunction

    task automatic build_hdr(input int n);
        logic [15:0] il = 16'(n + 28);
        logic [15:0] ul = 16'(n + 8);
        int unsigned s = 0;
        for (int b = 0; b < 6; b++) begin
            hb[b]     = dst_mac[47 - 8*b -: 8];
            hb[6 + b] = src_mac[47 - 8*b -: 8];
        end
        hb[12] = 8'h08; hb[13] = 8'h00; hb[14] = 8'h45; hb[15] = 8'h00;
        hb[16] = il[15:8];    hb[17] = il[7:0];
        hb[18] = ident[15:8]; hb[19] = ident[7:0];
        hb[20] = frag[15:8];  hb[21] = frag[7:0];
        hb[22] = 8'h40;       hb[23] = 8'h11;
        hb[24] = 8'h00;       hb[25] = 8'h00;
        for (int b = 0; b < 4; b++) begin
            hb[26 + b] = src_ip[31 - 8*b -: 8];
            hb[30 + b] = dst_ip[31 - 8*b -: 8];
        end
        hb[34] = src_port[15:8]; hb[35] = src_port[7:0];
        hb[36] = dst_port[15:8]; hb[37] = dst_port[7:0];
        hb[38] = ul[15:8];       hb[39] = ul[7:0];
        hb[40] = 8'h00;          hb[41] = 8'h00;
        for (int i = 14; i < 34; i += 2) s += {16'h0, hb[i], hb[i+1]};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        exp_csum = ~s[15:0];
        hb[24] = exp_csum[15:8];
        hb[25] = exp_csum[7:0];
    endtask

    function automatic logic [31:0] exp_word(input int k, input int n);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) begin
            int i = 4*k + b;
            w[31 - 8*b -: 8] = (i < 42) ? hb[i] : ((i < 42 + n) ? pbyte(i - 42) : 8'h00);
        end
        return w;
    endfunction

    function automatic logic [3:0] exp_keep(input int n);
        case ((42 + n) % 4)
            0: return 4'hF;
            1: return 4'h8;
            2: return 4'hC;
            default: return 4'hE;
        endcase
    endfunction

    task automatic set_fields(input int s);
        void'($urandom(s));
        dst_mac  = {$urandom, $urandom} ;
        src_mac  = {$urandom, $urandom};
        src_ip   = $urandom;
        dst_ip   = $urandom;
        src_port = 16'($urandom);
        dst_port = 16'($urandom);
        ident    = 16'($urandom);
        frag     = 16'($urandom);
        seed     = s;
    endtask

    task automatic run_frame(input int n, input bit stall, input bit poke);
        int k = 0, p = 0, cyc = 0, first = -1;
        int nw = (42 + n + 3) / 4;
        int pw = (n + 3) / 4;
        bit was_stall = 0;
        logic [31:0] held = '0;
        string r;
        build_hdr(n);
        @(negedge clk);
        pay_len = PLEN_W'(n);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (k < nw && cyc < 150000) begin
            cyc++;
            tx_ready  = stall ? (cyc % 3 != 0) : 1'b1;
            pay_valid = (p < pw) && (stall ? (cyc % 5 != 2) : 1'b1);
            pay_data  = {pbyte(4*p), pbyte(4*p+1), pbyte(4*p+2), pbyte(4*p+3)};
            if (poke && cyc == 12) begin
                start   = 1'b1;
                dst_mac = ~dst_mac;
                pay_len = PLEN_W'(n + 5);
            end else begin
                start = 1'b0;
            end
            #1;
            if (was_stall && k < 10) chk(tx_valid && tx_data == held, "R9 stalled word held", tx_data, held);
            if (tx_valid && first < 0) first = cyc;
            was_stall = tx_valid && !tx_ready;
            held      = tx_data;
            if (tx_valid && tx_ready) begin
                r = (k < 3) ? "R4" : (k < 6) ? "R5" : (k == 6) ? "R6" : (k < 10) ? "R7" :
                    (n == 0) ? "R12" : "R8";
                chk(tx_data == exp_word(k, n), r, tx_data, exp_word(k, n));
                chk(tx_last == (k == nw - 1), "R11 last flag", 32'(tx_last), 32'(k == nw - 1));
                chk(tx_keep == ((k == nw - 1) ? exp_keep(n) : 4'hF), "R11 keep",
                    32'(tx_keep), 32'((k == nw - 1) ? exp_keep(n) : 4'hF));
                k++;
            end
            if (pay_valid && pay_ready) p++;
            @(negedge clk);
        end
        start     = 1'b0;
        tx_ready  = 1'b0;
        pay_valid = 1'b0;
        chk(k == nw, "R11 word count", 32'(k), 32'(nw));
        if (!stall) chk(first == 7, "R3 first valid cycle", 32'(first), 32'd7);
        chk(p == pw, "R10 source words consumed", 32'(p), 32'(pw));
        chk(!busy, "R2 busy drops after last", 32'(busy), 32'd0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk(!busy && !tx_valid, "R2 start while busy ignored", 32'(busy), 32'd0);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 1'b0; tx_ready = 1'b0; pay_valid = 1'b0;
        pay_data = '0; pay_len = '0;
        set_fields(1);
        repeat (3) @(negedge clk);
        chk(!busy && !tx_valid && !pay_ready, "R1 in reset", {busy, tx_valid, pay_ready}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !tx_valid && !pay_ready, "R1 after reset", {busy, tx_valid, pay_ready}, 3'b000);
    endtask

    task automatic t_basic;
        dst_mac = 48'h0001_0203_0405; src_mac = 48'h0037_ffff_3737;
        src_ip = 32'hC0A8_0308; dst_ip = 32'hC0A8_0304;
        src_port = 16'd12345; dst_port = 16'd23456; ident = 16'h1234; frag = 16'h0000;
        seed = 3;
        run_frame(13, 1'b0, 1'b0);
    endtask

    task automatic t_tails;
        for (int n = 1; n <= 4; n++) begin
            set_fields(10 + n);
            run_frame(60 + n, 1'b1, 1'b0);
        end
        set_fields(20);
        run_frame(2, 1'b0, 1'b0);
    endtask

    task automatic t_zero;
        set_fields(30);
        run_frame(0, 1'b0, 1'b0);
        set_fields(31);
        run_frame(0, 1'b1, 1'b0);
    endtask

    task automatic t_busy_start;
        set_fields(40);
        run_frame(21, 1'b0, 1'b1);
    endtask

    task automatic t_carry;
        set_fields(50);
        ident = 16'hFFFF; frag = 16'hFFFF;
        src_ip = 32'hFFFF_FFFF; dst_ip = 32'hFFFF_FFFF;
        build_hdr(31444);
        chk(exp_csum == 16'hFFFD, "R6 double-fold model", 32'(exp_csum), 32'h0000FFFD);
        run_frame(31444, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_tails();
        t_zero();
        t_busy_start();
        t_carry();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule